// File: doc/BRIEF.md
# IDE Programmed-I/O Strobe Timing Generator

This block produces the chip-select window and the read/write strobes of a programmed-I/O cycle on a two-drive IDE channel. Every phase is counted in bus clocks. The block holds its own timing registers. Each drive has an address-setup count, a strobe byte for 16-bit reads, a strobe byte for 16-bit writes and a strobe byte for 8-bit command/control accesses. Each strobe byte packs an active count and a recovery count. Software loads these registers through a small write port that has nibble enables.

A cycle request carries a drive bit, a direction bit and a width bit. When the block is idle it accepts the request and latches the matching timing fields. It then runs three phases: address setup, strobe active and recovery. It raises a one-clock completion pulse on the final recovery clock and can accept the next request on the following clock. The timing suits bus clocks of roughly 25 to 33 MHz for PIO modes 0 to 4.

Top module: `ide_pio_strobe_gen`

## Requirements
- R1: After reset, `req_ready` is 1, `cs_active` and `done` are 0, and both strobes are high. Every timing field reads as 0xF, so a cycle issued without programming lasts 16 + 16 + 16 clocks.
- R2: A 4-bit timing field of value n produces a phase of n+1 clocks. Setup length is measured as the clocks in which `cs_active` is 1 and both strobes are high.
- R3: In a strobe byte, bits 7:4 set the strobe-active length and bits 3:0 set the recovery length that follows it. Recovery counts the clocks after the strobe rises, up to and including the `done` clock.
- R4: `req_drive`=0 selects the master registers and 1 selects the slave registers. The setup word at `wr_sel`=0 holds the master setup in bits 3:0 and the slave setup in bits 7:4.
- R5: `wr_sel` bit 2 selects the drive and bits 1:0 select the register: 1 = 16-bit read byte, 2 = 16-bit write byte, 3 = 8-bit byte. A request with `req_8bit`=1 uses the 8-bit byte for both directions. Otherwise a read uses the read byte and a write uses the write byte.
- R6: `wr_nib_en` bit 1 enables data bits 7:4 and bit 0 enables data bits 3:0, and a disabled nibble keeps its value. In the setup word, enable bit 0 covers the master nibble and bit 1 covers the slave nibble. A write with `wr_sel`=4 changes nothing.
- R7: `cs_active` is 1 from the first setup clock through the last active clock. Only `dior_n` goes low, and only in the active phase, for a read. Only `diow_n` goes low, and only in the active phase, for a write.
- R8: `done` is high for exactly one clock, the last recovery clock. `req_ready` is 1 on the next clock.
- R9: Timing fields are captured when a request is accepted. A register write made during a cycle does not change that cycle, but it does apply to the next cycle.
- R10: While a cycle is in progress `req_ready` is 0, and any `req` pulse in that time is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Timing register write strobe |
| wr_sel | input | 3 | Register select: bit 2 drive, bits 1:0 register kind |
| wr_data | input | 8 | Write data |
| wr_nib_en | input | 2 | Nibble enables (bit 1 upper, bit 0 lower) |
| req | input | 1 | Cycle request |
| req_drive | input | 1 | 0 master, 1 slave |
| req_write | input | 1 | 0 read, 1 write |
| req_8bit | input | 1 | 1 for an 8-bit command/control access |
| req_ready | output | 1 | Idle, a request is accepted this clock |
| cs_active | output | 1 | Chip-select/address window |
| dior_n | output | 1 | Read strobe, active low |
| diow_n | output | 1 | Write strobe, active low |
| done | output | 1 | One-clock completion pulse |

## Verification
A sweep steps the setup nibble through all sixteen values. On each step it loads distinct active and recovery nibbles into all six strobe bytes and runs all eight combinations of drive, direction and width. Because the values differ, measuring the wrong drive, the wrong register kind or swapped nibbles gives a different count. Separate sequences program single nibbles with partial enables and write to the unused select. They also rewrite the live byte in the middle of a cycle and pulse the request while the block is busy. These show that disabled fields stay put, that fields are captured at accept time and that requests made while busy are dropped.

// File: rtl/pio_tim_pkg.sv
package pio_tim_pkg;

    localparam int TIM_W   = 4;
    localparam int BYTE_W  = 2 * TIM_W;
    localparam int NUM_DRV = 2;
    localparam int DRV_W   = $clog2(NUM_DRV);
    localparam int KIND_W  = 2;
    localparam int SEL_W   = DRV_W + KIND_W;

    typedef logic [TIM_W-1:0] tim_t;

    // active nibble occupies the upper half of the byte
    typedef struct packed {
        tim_t active;
        tim_t recov;
    } strobe_byte_t;

    typedef enum logic [KIND_W-1:0] {
        K_SETUP = 2'd0,
        K_RD16  = 2'd1,
        K_WR16  = 2'd2,
        K_B8    = 2'd3
    } reg_kind_e;

    typedef struct packed {
        tim_t         setup;
        strobe_byte_t rd16;
        strobe_byte_t wr16;
        strobe_byte_t b8;
    } drive_tim_t;

    typedef struct packed {
        tim_t setup;
        tim_t active;
        tim_t recov;
        logic is_write;
    } cyc_tim_t;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SETUP  = 2'd1,
        PH_ACTIVE = 2'd2,
        PH_RECOV  = 2'd3
    } phase_e;

    function automatic strobe_byte_t merge_byte(strobe_byte_t old_b,
                                                logic [BYTE_W-1:0] d,
                                                logic [1:0] en);
        strobe_byte_t r;
        r = old_b;
        if (en[1]) r.active = d[BYTE_W-1:TIM_W];
        if (en[0]) r.recov  = d[TIM_W-1:0];
        return r;
    endfunction

    function automatic drive_tim_t slowest_drive();
        drive_tim_t r;
        r = '1;
        return r;
    endfunction

endpackage

// File: rtl/pio_timing_regs.sv
module pio_timing_regs
    import pio_tim_pkg::*;
(
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           wr_en,
    input  logic [SEL_W-1:0]               wr_sel,
    input  logic [BYTE_W-1:0]              wr_data,
    input  logic [1:0]                     wr_nib_en,
    output drive_tim_t [NUM_DRV-1:0]       drv_tim
);

    reg_kind_e         kind;
    logic [DRV_W-1:0]  drv_bit;

    assign kind    = reg_kind_e'(wr_sel[KIND_W-1:0]);
    assign drv_bit = wr_sel[SEL_W-1:KIND_W];

    // setup nibbles of all drives live at select 0
    logic setup_hit;
    assign setup_hit = wr_en && (wr_sel == '0);

    for (genvar d = 0; d < NUM_DRV; d++) begin : g_drive
        drive_tim_t r_q;
        logic       byte_hit;

        assign byte_hit = wr_en && (drv_bit == DRV_W'(d)) && (kind != K_SETUP);

        always_ff @(posedge clk) begin
            if (rst) begin
                r_q <= slowest_drive();
            end else begin
                if (setup_hit && wr_nib_en[d])
                    r_q.setup <= wr_data[d*TIM_W +: TIM_W];
                if (byte_hit) begin
                    case (kind)
                        K_RD16:  r_q.rd16 <= merge_byte(r_q.rd16, wr_data, wr_nib_en);
                        K_WR16:  r_q.wr16 <= merge_byte(r_q.wr16, wr_data, wr_nib_en);
                        K_B8:    r_q.b8   <= merge_byte(r_q.b8,   wr_data, wr_nib_en);
                        default: ;
                    endcase
                end
            end
        end

        assign drv_tim[d] = r_q;
    end

endmodule

// File: rtl/pio_cycle_select.sv
module pio_cycle_select
    import pio_tim_pkg::*;
(
    input  drive_tim_t [NUM_DRV-1:0] drv_tim,
    input  logic [DRV_W-1:0]         req_drive,
    input  logic                     req_write,
    input  logic                     req_8bit,
    output cyc_tim_t                 sel_tim
);

    drive_tim_t   dt;
    strobe_byte_t sb;

    always_comb begin
        dt = drv_tim[req_drive];
        if (req_8bit)
            sb = dt.b8;
        else if (req_write)
            sb = dt.wr16;
        else
            sb = dt.rd16;
        sel_tim.setup    = dt.setup;
        sel_tim.active   = sb.active;
        sel_tim.recov    = sb.recov;
        sel_tim.is_write = req_write;
    end

endmodule

// File: rtl/pio_phase_seq.sv
module pio_phase_seq
    import pio_tim_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     req,
    input  cyc_tim_t sel_tim,
    output logic     req_ready,
    output logic     cs_active,
    output logic     dior_n,
    output logic     diow_n,
    output logic     done
);

    phase_e   phase_q;
    tim_t     cnt_q;
    cyc_tim_t cyc_q;
    logic     last_clk;

    assign last_clk = (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
            cyc_q   <= '1;
        end else begin
            case (phase_q)
                PH_IDLE: begin
                    if (req) begin
                        cyc_q   <= sel_tim;
                        cnt_q   <= sel_tim.setup;
                        phase_q <= PH_SETUP;
                    end
                end
                PH_SETUP: begin
                    if (last_clk) begin
                        cnt_q   <= cyc_q.active;
                        phase_q <= PH_ACTIVE;
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                PH_ACTIVE: begin
                    if (last_clk) begin
                        cnt_q   <= cyc_q.recov;
                        phase_q <= PH_RECOV;
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                PH_RECOV: begin
                    if (last_clk)
                        phase_q <= PH_IDLE;
                    else
                        cnt_q <= cnt_q - 1'b1;
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    assign req_ready = (phase_q == PH_IDLE);
    assign cs_active = (phase_q == PH_SETUP) || (phase_q == PH_ACTIVE);
    assign dior_n    = !((phase_q == PH_ACTIVE) && !cyc_q.is_write);
    assign diow_n    = !((phase_q == PH_ACTIVE) &&  cyc_q.is_write);
    assign done      = (phase_q == PH_RECOV) && last_clk;

endmodule

// File: rtl/ide_pio_strobe_gen.sv
module ide_pio_strobe_gen
    import pio_tim_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [2:0]  wr_sel,
    input  logic [7:0]  wr_data,
    input  logic [1:0]  wr_nib_en,
    input  logic        req,
    input  logic        req_drive,
    input  logic        req_write,
    input  logic        req_8bit,
    output logic        req_ready,
    output logic        cs_active,
    output logic        dior_n,
    output logic        diow_n,
    output logic        done
);

    drive_tim_t [NUM_DRV-1:0] drv_tim;
    cyc_tim_t                 sel_tim;

    pio_timing_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_sel    (wr_sel),
        .wr_data   (wr_data),
        .wr_nib_en (wr_nib_en),
        .drv_tim   (drv_tim)
    );

    pio_cycle_select u_sel (
        .drv_tim   (drv_tim),
        .req_drive (req_drive),
        .req_write (req_write),
        .req_8bit  (req_8bit),
        .sel_tim   (sel_tim)
    );

    pio_phase_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .req       (req),
        .sel_tim   (sel_tim),
        .req_ready (req_ready),
        .cs_active (cs_active),
        .dior_n    (dior_n),
        .diow_n    (diow_n),
        .done      (done)
    );

endmodule

// File: rtl/pio_strobe_chk.sv
module pio_strobe_chk (
    input logic clk,
    input logic rst,
    input logic req,
    input logic req_ready,
    input logic cs_active,
    input logic dior_n,
    input logic diow_n,
    input logic done
);

    // R1: one clock after reset the channel is quiet and idle
    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> (dior_n && diow_n && !cs_active && !done && req_ready));

    // R7: never both strobes at once
    assert_one_strobe_R7: assert property (@(posedge clk) disable iff (rst)
        !(!dior_n && !diow_n));

    // R7: a strobe only inside the chip-select window
    assert_strobe_in_cs_R7: assert property (@(posedge clk) disable iff (rst)
        (!dior_n || !diow_n) |-> cs_active);

    // R7: an accepted request opens setup with strobes high
    assert_accept_setup_R7: assert property (@(posedge clk) disable iff (rst)
        (req && req_ready) |=> (cs_active && dior_n && diow_n && !req_ready));

    // R8: done falls in recovery and lasts one clock, idle follows
    assert_done_recov_R8: assert property (@(posedge clk) disable iff (rst)
        done |-> (!cs_active && dior_n && diow_n && !req_ready));

    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        done |=> (!done && req_ready));

    // R10: busy whenever the window is open
    assert_busy_R10: assert property (@(posedge clk) disable iff (rst)
        cs_active |-> !req_ready);

endmodule

bind ide_pio_strobe_gen pio_strobe_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .req       (req),
    .req_ready (req_ready),
    .cs_active (cs_active),
    .dior_n    (dior_n),
    .diow_n    (diow_n),
    .done      (done)
);

// File: tb/tb_ide_pio_strobe_gen.sv
`timescale 1ns/1ps
module tb_ide_pio_strobe_gen;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [2:0] wr_sel = '0;
    logic [7:0] wr_data = '0;
    logic [1:0] wr_nib_en = '0;
    logic       req = 1'b0;
    logic       req_drive = 1'b0;
    logic       req_write = 1'b0;
    logic       req_8bit = 1'b0;
    logic       req_ready, cs_active, dior_n, diow_n, done;

    int n_vec  = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    // bench-side copy of what was written
    logic [7:0] sh_setup;
    logic [7:0] sh_byte [8];

    always #4 clk = ~clk;

    ide_pio_strobe_gen dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .wr_nib_en(wr_nib_en), .req(req), .req_drive(req_drive), .req_write(req_write),
        .req_8bit(req_8bit), .req_ready(req_ready), .cs_active(cs_active),
        .dior_n(dior_n), .diow_n(diow_n), .done(done)
    );

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", rq, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] mrg(logic [7:0] o, logic [7:0] d, logic [1:0] en);
        logic [7:0] r;
        r = o;
        if (en[1]) r[7:4] = d[7:4];
        if (en[0]) r[3:0] = d[3:0];
        return r;
    endfunction

    function automatic void shadow_write(logic [2:0] sel, logic [7:0] d, logic [1:0] en);
        if (sel == 3'd0)      sh_setup = mrg(sh_setup, d, en);
        else if (sel != 3'd4) sh_byte[sel] = mrg(sh_byte[sel], d, en);
    endfunction

    task automatic wr_reg(input logic [2:0] sel, input logic [7:0] d, input logic [1:0] en);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d; wr_nib_en = en;
        @(negedge clk);
        wr_en = 1'b0;
        shadow_write(sel, d, en);
    endtask

    // runs one cycle and measures its three phases
    task automatic run_cycle(input bit drv, input bit wr, input bit b8,
                             input bit mid_wr, input bit glitch);
        int e_s, e_a, e_r, ns, na, nr, wrong, busy_err;
        bit order_err, seen_done;
        logic [2:0] code;
        code = b8 ? 3'd3 : (wr ? 3'd2 : 3'd1);
        e_s = (drv ? int'(sh_setup[7:4]) : int'(sh_setup[3:0])) + 1;
        e_a = int'(sh_byte[{drv, code[1:0]}][7:4]) + 1;
        e_r = int'(sh_byte[{drv, code[1:0]}][3:0]) + 1;
        ns = 0; na = 0; nr = 0; wrong = 0; busy_err = 0;
        order_err = 1'b0; seen_done = 1'b0;
        @(negedge clk);
        for (int w = 0; w < 100 && !req_ready; w++) @(negedge clk);
        req = 1'b1; req_drive = drv; req_write = wr; req_8bit = b8;
        @(negedge clk);
        req = 1'b0;
        if (mid_wr) begin
            wr_en = 1'b1; wr_sel = {drv, code[1:0]}; wr_data = 8'h21; wr_nib_en = 2'b11;
        end
        for (int k = 0; k < 80; k++) begin
            if (k == 1) begin
                if (mid_wr) begin
                    wr_en = 1'b0;
                    shadow_write({drv, code[1:0]}, 8'h21, 2'b11);
                end
                if (glitch) begin req = 1'b1; req_drive = ~drv; end
            end
            if (k == 3) req = 1'b0;
            if (req_ready) busy_err++;
            if (done) begin
                nr++; seen_done = 1'b1;
                break;
            end else if (!dior_n || !diow_n) begin
                if (nr > 0) order_err = 1'b1;
                na++;
                if (wr ? !(!diow_n && dior_n) : !(!dior_n && diow_n)) wrong++;
                if (!cs_active) wrong++;
            end else if (cs_active) begin
                if (na > 0) order_err = 1'b1;
                ns++;
            end else begin
                if (na == 0) order_err = 1'b1;
                nr++;
            end
            @(negedge clk);
        end
        chk(ns == e_s, "R2 R4 setup clocks", ns, e_s);
        chk(na == e_a, "R3 R5 active clocks", na, e_a);
        chk(nr == e_r, "R3 R5 recovery clocks", nr, e_r);
        chk(wrong == 0 && !order_err, "R7 strobe/phase order", wrong + int'(order_err), 0);
        chk(seen_done && busy_err == 0, "R8 R10 done seen, busy held", busy_err, 0);
        @(negedge clk);
        chk(!done && req_ready && !cs_active, "R8 R10 idle after done",
            int'(done) + int'(cs_active), 0);
    endtask

    initial begin
        for (int i = 0; i < 8; i++) sh_byte[i] = 8'hFF;
        sh_setup = 8'hFF;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk(req_ready && !cs_active && !done && dior_n && diow_n, "R1 reset outputs",
            int'(cs_active) + int'(done), 0);
        run_cycle(1'b0, 1'b0, 1'b0, 1'b0, 1'b0);   // R1 slowest default
        run_cycle(1'b1, 1'b1, 1'b1, 1'b0, 1'b1);   // R10 request pulses while busy

        // R2 R3 R4 R5 sweep over all setup values and all access combinations
        for (int v = 0; v < 16; v++) begin
            wr_reg(3'd0, {4'((v + 3) % 16), 4'(v)}, 2'b11);
            for (int d = 0; d < 2; d++)
                for (int kd = 1; kd < 4; kd++)
                    wr_reg({1'(d), 2'(kd)},
                           {4'((v + d * 5 + kd) % 16), 4'((15 - v + kd * 2 + d) % 16)}, 2'b11);
            for (int d = 0; d < 2; d++)
                for (int c = 0; c < 4; c++)
                    run_cycle(1'(d), c[0], c[1], 1'b0, 1'b0);
        end

        // R6 nibble enables and the unused select
        wr_reg(3'd0, 8'h9C, 2'b10);        // slave setup only
        wr_reg(3'd1, 8'h00, 2'b01);        // master read recovery only
        wr_reg(3'd6, 8'h7E, 2'b10);        // slave write active only
        wr_reg(3'd4, 8'h00, 2'b11);        // ignored
        wr_reg(3'd7, 8'h55, 2'b00);        // no enable, ignored
        run_cycle(1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        run_cycle(1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
        run_cycle(1'b1, 1'b0, 1'b1, 1'b0, 1'b0);

        // R9 rewrite the live byte mid-cycle, then confirm it lands next time
        wr_reg(3'd2, 8'hA6, 2'b11);
        run_cycle(1'b0, 1'b1, 1'b0, 1'b1, 1'b0);
        run_cycle(1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
        run_cycle(1'b1, 1'b0, 1'b1, 1'b1, 1'b1);
        run_cycle(1'b1, 1'b0, 1'b1, 1'b0, 1'b0);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_vec++; n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

endmodule